// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block is the exception-entry controller of an 8-bit processor that has two accumulators, a 16-bit index register, a 16-bit stack pointer, a 16-bit program counter and an 8-bit condition code register. It watches an active-low non-maskable request line, an active-low maskable request line and two instruction-level requests from the decoder (software trap and return-from-trap). The decoder tells it when an instruction has completed. At that boundary the sequencer picks at most one request. For a trap it stacks the whole register file one byte per clock through a byte-wide memory port, fetches a two-byte vector and hands the new program counter, stack pointer and condition codes back to the core. For a return it pops the frame and hands every register back.

Reset is handled differently. A synchronous active-high reset abandons whatever the sequencer was doing, stacks nothing, and then fetches the reset vector. The condition codes it hands back have the interrupt mask set. While the sequencer works it raises `busy`, which the core uses to stall instruction fetch.

Condition code layout: bits 7:6 always read 1; bit 5 half carry, bit 4 interrupt mask, bit 3 negative, bit 2 zero, bit 1 overflow, bit 0 carry. Vector pairs sit at the top of memory, high byte at the even address: maskable request FFF8h, software trap FFFAh, non-maskable request FFFCh, reset FFFEh.

Top module: `isq_top`

## Requirements
- R1: While `rst` is high, `busy` is 1 and no memory write happens. After `rst` falls, the block reads FFFEh then FFFFh. In the third cycle after release, `vec_load` pulses with `pc_out` = {byte at FFFEh, byte at FFFFh} and `ccr_out` = D0h.
- R2: A reset that arrives during a stacking sequence stops it at once: no further write occurs, and the reset vector fetch of R1 follows.
- R3: On a trap entry, seven bytes are written to addresses SP, SP-1, ... SP-6, where SP is the `sp_in` value at the boundary. The order is PC low, PC high, X low, X high, A, B, then CCR with bits 7:6 forced to 1.
- R4: After stacking, the vector high byte is read and then the low byte. `vec_load` then pulses with `pc_out` = the vector, `sp_out` = SP-7, and `ccr_out` = the boundary CCR with bits 7:6 and the mask bit 4 set.
- R5: Vector base addresses: maskable request FFF8h, software trap FFFAh, non-maskable request FFFCh, reset FFFEh.
- R6: A falling edge of `nmi_n` is remembered until it is serviced, even with no boundary in between. Holding `nmi_n` low does not start a second entry.
- R7: A low level of `irq_n` is taken at a boundary only when `ccr_in` bit 4 is 0. With bit 4 set, it is ignored and `busy` stays 0.
- R8: When a non-maskable request and an unmasked maskable request are both present at a boundary, the non-maskable vector FFFCh is used.
- R9: Requests are examined only when `instr_done` is 1 while idle. A completing software trap or return takes precedence at that boundary. A pending non-maskable request is then served at the next boundary.
- R10: A return reads SP+1 through SP+7 (CCR, B, A, X high, X low, PC high, PC low). `rf_restore` then pulses with every register restored, `ccr_out` bits 7:6 = 1 (mask restored as stacked), and `sp_out` = SP+7.
- R11: `vec_load` appears exactly 10 cycles after the boundary cycle of a trap entry, and `rf_restore` exactly 8 cycles after that of a return.
- R12: Memory read and write strobes are never active together, and either one implies `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the reset vector fetch |
| nmi_n | input | 1 | Non-maskable request, active low, falling-edge sensitive |
| irq_n | input | 1 | Maskable request, active low, level sensitive |
| instr_done | input | 1 | Current instruction completes this cycle |
| swi_req | input | 1 | Completing instruction is a software trap |
| rti_req | input | 1 | Completing instruction is a return-from-trap |
| pc_in | input | 16 | Program counter of the next instruction |
| sp_in | input | 16 | Current stack pointer |
| x_in | input | 16 | Index register |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| ccr_in | input | 8 | Condition code register; bit 4 is the mask |
| mem_rdata | input | 8 | Read data, valid in the cycle of `mem_re` |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| busy | output | 1 | Sequencer active; stall fetch |
| vec_load | output | 1 | Load PC, SP and CCR from the outputs |
| rf_restore | output | 1 | Load every register from the outputs |
| pc_out | output | 16 | New program counter |
| sp_out | output | 16 | New stack pointer |
| x_out | output | 16 | Restored index register |
| a_out | output | 8 | Restored accumulator A |
| b_out | output | 8 | Restored accumulator B |
| ccr_out | output | 8 | New condition code register |

## Verification
A wrong byte index or a corrupted snapshot shows up on `mem_wdata` in the very stacking cycle where it occurs. A wrong stack pointer step shows on `mem_addr` one cycle after the slip. A wrong source selection appears two cycles after stacking ends, as a vector address outside the expected pair. A stuck or lost non-maskable pending flag stays hidden until the next instruction boundary. It then shows as a spurious or missing `busy` in the following cycle, so the sweeps hold the request line low across boundaries and leave idle gaps between the edge and the boundary.

// File: rtl/isq_pkg.sv
package isq_pkg;
    localparam int AW          = 16;
    localparam int DW          = 8;
    localparam int FRAME_BYTES = 7;
    localparam int IDX_W       = $clog2(FRAME_BYTES);
    localparam int CCR_I       = 4;

    localparam logic [AW-1:0] VEC_BASE  = 16'hFFF8;
    localparam logic [DW-1:0] CCR_ONES  = 8'hC0;
    localparam logic [DW-1:0] CCR_IMASK = DW'(1) << CCR_I;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BYTES - 1);

    // source order sets the vector slot: base + 2*source
    typedef enum logic [1:0] {
        SRC_IRQ = 2'd0,
        SRC_SWI = 2'd1,
        SRC_NMI = 2'd2,
        SRC_RST = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_IDLE,
        ST_PUSH,
        ST_POP,
        ST_VHI,
        ST_VLO,
        ST_VFIN,
        ST_RFIN
    } state_e;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] x;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] ccr;
    } frame_t;

    function automatic logic [DW-1:0] ccr_fix(logic [DW-1:0] c);
        return c | CCR_ONES;
    endfunction

    function automatic logic [AW-1:0] vec_addr(src_e s);
        return VEC_BASE | AW'({s, 1'b0});
    endfunction

    // slot k is the k-th byte pushed
    function automatic logic [DW-1:0] frame_byte(frame_t f, logic [IDX_W-1:0] k);
        logic [DW-1:0] r;
        case (int'(k))
            0: r = f.pc[DW-1:0];
            1: r = f.pc[AW-1:DW];
            2: r = f.x[DW-1:0];
            3: r = f.x[AW-1:DW];
            4: r = f.a;
            5: r = f.b;
            default: r = ccr_fix(f.ccr);
        endcase
        return r;
    endfunction

    function automatic frame_t frame_put(frame_t f, logic [IDX_W-1:0] k, logic [DW-1:0] d);
        frame_t r;
        r = f;
        case (int'(k))
            0: r.pc[DW-1:0]  = d;
            1: r.pc[AW-1:DW] = d;
            2: r.x[DW-1:0]   = d;
            3: r.x[AW-1:DW]  = d;
            4: r.a           = d;
            5: r.b           = d;
            default: r.ccr   = ccr_fix(d);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/isq_req_front.sv
module isq_req_front (
    input  logic clk,
    input  logic rst,
    input  logic nmi_n,
    input  logic irq_n,
    input  logic mask,
    input  logic nmi_take,
    output logic nmi_pend,
    output logic irq_live
);
    logic nmi_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev <= 1'b1;
            nmi_pend <= 1'b0;
        end else begin
            nmi_prev <= nmi_n;
            // a new edge in the grant cycle stays pending
            nmi_pend <= (nmi_prev & ~nmi_n) | (nmi_pend & ~nmi_take);
        end
    end

    assign irq_live = ~irq_n & ~mask;
endmodule

// File: rtl/isq_seq_ctrl.sv
module isq_seq_ctrl
    import isq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_done,
    input  logic             swi_req,
    input  logic             rti_req,
    input  logic             nmi_pend,
    input  logic             irq_live,
    output state_e           st,
    output logic [IDX_W-1:0] idx,
    output src_e             src,
    output logic             grab,
    output logic             nmi_take
);
    logic at_edge, go_swi, go_rti, go_nmi, go_irq;

    always_comb begin
        at_edge  = (st == ST_IDLE) && instr_done;
        go_swi   = at_edge && swi_req;
        go_rti   = at_edge && !swi_req && rti_req;
        go_nmi   = at_edge && !swi_req && !rti_req && nmi_pend;
        go_irq   = at_edge && !swi_req && !rti_req && !nmi_pend && irq_live;
        grab     = go_swi || go_rti || go_nmi || go_irq;
        nmi_take = go_nmi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_HOLD;
            idx <= '0;
            src <= SRC_RST;
        end else begin
            case (st)
                ST_HOLD: st <= ST_VHI;
                ST_IDLE: begin
                    idx <= '0;
                    if (go_rti) begin
                        st <= ST_POP;
                    end else if (go_swi) begin
                        st  <= ST_PUSH;
                        src <= SRC_SWI;
                    end else if (go_nmi) begin
                        st  <= ST_PUSH;
                        src <= SRC_NMI;
                    end else if (go_irq) begin
                        st  <= ST_PUSH;
                        src <= SRC_IRQ;
                    end
                end
                ST_PUSH: begin
                    if (idx == IDX_LAST) st <= ST_VHI;
                    else                 idx <= idx + 1'b1;
                end
                ST_POP: begin
                    if (idx == IDX_LAST) st <= ST_RFIN;
                    else                 idx <= idx + 1'b1;
                end
                ST_VHI:  st <= ST_VLO;
                ST_VLO:  st <= ST_VFIN;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/isq_frame_dp.sv
module isq_frame_dp
    import isq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  state_e           st,
    input  logic [IDX_W-1:0] idx,
    input  src_e             src,
    input  logic             grab,
    input  logic [AW-1:0]    pc_in,
    input  logic [AW-1:0]    sp_in,
    input  logic [AW-1:0]    x_in,
    input  logic [DW-1:0]    a_in,
    input  logic [DW-1:0]    b_in,
    input  logic [DW-1:0]    ccr_in,
    input  logic [DW-1:0]    mem_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_we,
    output logic             mem_re,
    output frame_t           frm,
    output logic [AW-1:0]    sp_r
);
    logic [DW-1:0] vhi;

    always_ff @(posedge clk) begin
        if (rst) begin
            frm  <= '0;
            sp_r <= sp_in;
            vhi  <= '0;
        end else begin
            if (grab) begin
                frm  <= '{pc: pc_in, x: x_in, a: a_in, b: b_in, ccr: ccr_in};
                sp_r <= sp_in;
            end
            case (st)
                ST_PUSH: sp_r <= sp_r - 1'b1;
                ST_POP: begin
                    sp_r <= sp_r + 1'b1;
                    frm  <= frame_put(frm, IDX_LAST - idx, mem_rdata);
                end
                ST_VHI: vhi <= mem_rdata;
                ST_VLO: begin
                    frm.pc  <= {vhi, mem_rdata};
                    frm.ccr <= ccr_fix(frm.ccr) | CCR_IMASK;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        case (st)
            ST_PUSH: begin
                mem_addr  = sp_r;
                mem_wdata = frame_byte(frm, idx);
                mem_we    = 1'b1;
            end
            ST_POP: begin
                mem_addr = sp_r + 1'b1;
                mem_re   = 1'b1;
            end
            ST_VHI: begin
                mem_addr = vec_addr(src);
                mem_re   = 1'b1;
            end
            ST_VLO: begin
                mem_addr = vec_addr(src) | AW'(1);
                mem_re   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/isq_top.sv
module isq_top
    import isq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          nmi_n,
    input  logic          irq_n,
    input  logic          instr_done,
    input  logic          swi_req,
    input  logic          rti_req,
    input  logic [15:0]   pc_in,
    input  logic [15:0]   sp_in,
    input  logic [15:0]   x_in,
    input  logic [7:0]    a_in,
    input  logic [7:0]    b_in,
    input  logic [7:0]    ccr_in,
    input  logic [7:0]    mem_rdata,
    output logic [15:0]   mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    output logic          busy,
    output logic          vec_load,
    output logic          rf_restore,
    output logic [15:0]   pc_out,
    output logic [15:0]   sp_out,
    output logic [15:0]   x_out,
    output logic [7:0]    a_out,
    output logic [7:0]    b_out,
    output logic [7:0]    ccr_out
);
    state_e           st;
    logic [IDX_W-1:0] idx;
    src_e             src;
    logic             grab, nmi_take, nmi_pend, irq_live;
    frame_t           frm;
    logic [AW-1:0]    sp_r;

    isq_req_front u_front (
        .clk      (clk),
        .rst      (rst),
        .nmi_n    (nmi_n),
        .irq_n    (irq_n),
        .mask     (ccr_in[CCR_I]),
        .nmi_take (nmi_take),
        .nmi_pend (nmi_pend),
        .irq_live (irq_live)
    );

    isq_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .instr_done (instr_done),
        .swi_req    (swi_req),
        .rti_req    (rti_req),
        .nmi_pend   (nmi_pend),
        .irq_live   (irq_live),
        .st         (st),
        .idx        (idx),
        .src        (src),
        .grab       (grab),
        .nmi_take   (nmi_take)
    );

    isq_frame_dp u_dp (
        .clk       (clk),
        .rst       (rst),
        .st        (st),
        .idx       (idx),
        .src       (src),
        .grab      (grab),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .x_in      (x_in),
        .a_in      (a_in),
        .b_in      (b_in),
        .ccr_in    (ccr_in),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .frm       (frm),
        .sp_r      (sp_r)
    );

    assign busy       = (st != ST_IDLE);
    assign vec_load   = (st == ST_VFIN);
    assign rf_restore = (st == ST_RFIN);
    assign pc_out     = frm.pc;
    assign sp_out     = sp_r;
    assign x_out      = frm.x;
    assign a_out      = frm.a;
    assign b_out      = frm.b;
    assign ccr_out    = frm.ccr;
endmodule

// File: rtl/isq_checker.sv
module isq_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic        mem_re,
    input logic        busy,
    input logic        vec_load,
    input logic        rf_restore,
    input logic [7:0]  ccr_out
);
    p_excl_access_r12: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    p_busy_cover_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> busy);

    p_push_walk_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd1));

    p_read_step_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + 16'd1));

    p_vec_pair_r4: assert property (@(posedge clk) disable iff (rst)
        vec_load |-> ($past(mem_re) && $past(mem_addr[0]) && ($past(mem_addr[15:3]) == 13'h1FFF)));

    p_mask_set_r4: assert property (@(posedge clk) disable iff (rst)
        vec_load |-> (ccr_out[4] && (ccr_out[7:6] == 2'b11)));

    p_restore_after_read_r10: assert property (@(posedge clk) disable iff (rst)
        rf_restore |-> ($past(mem_re) && (ccr_out[7:6] == 2'b11)));
endmodule

bind isq_top isq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .busy       (busy),
    .vec_load   (vec_load),
    .rf_restore (rf_restore),
    .ccr_out    (ccr_out)
);

// File: tb/sim_isq_top.sv
`timescale 1ns/1ps
module sim_isq_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1, nmi_n = 1'b1, irq_n = 1'b1;
    logic        instr_done = 1'b0, swi_req = 1'b0, rti_req = 1'b0;
    logic [15:0] pc_i = '0, sp_i = 16'h01F0, x_i = '0;
    logic [7:0]  a_i = '0, b_i = '0, ccr_i = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr, pc_out, sp_out, x_out;
    logic [7:0]  mem_wdata, a_out, b_out, ccr_out;
    logic        mem_we, mem_re, busy, vec_load, rf_restore;

    int nvec = 0, nbad = 0, wn = 0, rn = 0, ticks = 0;
    logic [15:0] wr_addr [1024];
    logic [7:0]  wr_data [1024];
    logic [15:0] rd_addr [1024];
    logic [7:0]  stk [256];

    function automatic logic [15:0] vword(input logic [1:0] s);
        case (s)
            2'd0: return 16'h9ABC;
            2'd1: return 16'h2233;
            2'd2: return 16'h5678;
            default: return 16'hE000;
        endcase
    endfunction

    function automatic logic [7:0] mem_byte(input logic [15:0] ad);
        logic [15:0] w;
        if (ad[15:3] == 13'h1FFF) begin
            w = vword(ad[2:1]);
            return ad[0] ? w[7:0] : w[15:8];
        end
        return stk[ad[7:0]];
    endfunction

    assign mem_rdata = mem_byte(mem_addr);

    isq_top u0 (
        .clk(clk), .rst(rst), .nmi_n(nmi_n), .irq_n(irq_n),
        .instr_done(instr_done), .swi_req(swi_req), .rti_req(rti_req),
        .pc_in(pc_i), .sp_in(sp_i), .x_in(x_i), .a_in(a_i), .b_in(b_i), .ccr_in(ccr_i),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .busy(busy), .vec_load(vec_load),
        .rf_restore(rf_restore), .pc_out(pc_out), .sp_out(sp_out), .x_out(x_out),
        .a_out(a_out), .b_out(b_out), .ccr_out(ccr_out)
    );

    // memory model and access log, away from the active edge
    always @(negedge clk) begin
        ticks++;
        if (mem_we) begin
            wr_addr[wn % 1024] = mem_addr;
            wr_data[wn % 1024] = mem_wdata;
            stk[mem_addr[7:0]] = mem_wdata;
            wn++;
        end
        if (mem_re) begin
            rd_addr[rn % 1024] = mem_addr;
            rn++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [7:0] exp_byte(input int k, input logic [15:0] pc, x,
                                            input logic [7:0] a, b, c);
        case (k)
            0: return pc[7:0];
            1: return pc[15:8];
            2: return x[7:0];
            3: return x[15:8];
            4: return a;
            5: return b;
            default: return c | 8'hC0;
        endcase
    endfunction

    task automatic nmi_edge();
        tick(); nmi_n = 1'b0;
        tick(); nmi_n = 1'b1;
    endtask

    task automatic run_entry(input logic [1:0] vs, input logic [15:0] sp, pc, x,
                             input logic [7:0] a, b, c, input bit use_swi);
        int w0, r0, lat;
        logic [15:0] base;
        tick();
        sp_i = sp; pc_i = pc; x_i = x; a_i = a; b_i = b; ccr_i = c;
        swi_req = use_swi; instr_done = 1'b1;
        w0 = wn; r0 = rn; lat = 0;
        while (lat < 40) begin
            tick(); lat++;
            instr_done = 1'b0; swi_req = 1'b0;
            if (vec_load) break;
        end
        base = 16'hFFF8 + {13'd0, vs, 1'b0};
        chk("R11 entry latency", lat, 10);
        chk("R3 write count", wn - w0, 7);
        for (int k = 0; k < 7; k++) begin
            chk("R3 push address", wr_addr[(w0 + k) % 1024], sp - 16'(k));
            chk("R3 push data", wr_data[(w0 + k) % 1024], exp_byte(k, pc, x, a, b, c));
        end
        chk("R4 vector read count", rn - r0, 2);
        chk("R5 vector high address", rd_addr[r0 % 1024], base);
        chk("R4 vector low address", rd_addr[(r0 + 1) % 1024], base + 16'd1);
        chk("R4 new pc", pc_out, vword(vs));
        chk("R4 new sp", sp_out, sp - 16'd7);
        chk("R4 new ccr", ccr_out, c | 8'hD0);
        tick();
        chk("R11 idle after entry", busy, 0);
    endtask

    task automatic run_rti(input logic [15:0] sp, pc, x, input logic [7:0] a, b, c);
        int r0, lat;
        tick();
        sp_i = sp; pc_i = ~pc; x_i = ~x; a_i = ~a; b_i = ~b;
        rti_req = 1'b1; instr_done = 1'b1;
        r0 = rn; lat = 0;
        while (lat < 40) begin
            tick(); lat++;
            instr_done = 1'b0; rti_req = 1'b0;
            if (rf_restore) break;
        end
        chk("R11 return latency", lat, 8);
        chk("R10 pop count", rn - r0, 7);
        for (int k = 0; k < 7; k++)
            chk("R10 pop address", rd_addr[(r0 + k) % 1024], sp + 16'(k + 1));
        chk("R10 pc", pc_out, pc);
        chk("R10 x", x_out, x);
        chk("R10 a", a_out, a);
        chk("R10 b", b_out, b);
        chk("R10 ccr", ccr_out, c | 8'hC0);
        chk("R10 sp", sp_out, sp + 16'd7);
        tick();
        chk("R10 idle after return", busy, 0);
    endtask

    task automatic reset_seq(input string tag);
        int r0, lat;
        r0 = rn; lat = 0;
        rst = 1'b0;
        while (lat < 20) begin
            tick(); lat++;
            if (vec_load) break;
        end
        chk({tag, " reset latency"}, lat, 3);
        chk({tag, " reset reads"}, rn - r0, 2);
        chk({tag, " reset vector hi addr"}, rd_addr[r0 % 1024], 16'hFFFE);
        chk({tag, " reset vector lo addr"}, rd_addr[(r0 + 1) % 1024], 16'hFFFF);
        chk({tag, " reset pc"}, pc_out, 16'hE000);
        chk({tag, " reset ccr"}, ccr_out, 8'hD0);
        tick();
    endtask

    initial begin
        int w0;
        logic [15:0] sp, pc, x;
        logic [7:0]  a, b, c;
        logic [1:0]  vs;

        for (int k = 0; k < 256; k++) stk[k] = 8'h00;

        // R1: reset state and reset vector
        repeat (3) tick();
        chk("R1 busy in reset", busy, 1);
        chk("R1 no write in reset", mem_we, 0);
        chk("R1 no load in reset", vec_load, 0);
        w0 = wn;
        reset_seq("R1");
        chk("R1 no stacking on reset", wn - w0, 0);

        // R3 R4 R5 R10 R11 sweep: three trap sources, four register patterns
        for (int s = 0; s < 3; s++) begin
            for (int p = 0; p < 4; p++) begin
                vs = (s == 0) ? 2'd0 : (s == 1) ? 2'd1 : 2'd2;
                pc = 16'h1357 * 16'(p + 1) + 16'(s);
                x  = 16'hA5A5 ^ (pc << 1);
                a  = 8'h11 * 8'(p + 1) + 8'(s);
                b  = ~a ^ 8'(p * 3);
                c  = 8'((p * 13 + s * 5 + 7) % 64);
                if (vs == 2'd0) c[4] = 1'b0;
                sp = 16'h01F0 - 16'(p * 32) - 16'(s * 8);
                if (vs == 2'd0) irq_n = 1'b0;
                if (vs == 2'd2) nmi_edge();
                run_entry(vs, sp, pc, x, a, b, c, vs == 2'd1);
                irq_n = 1'b1;
                run_rti(sp - 16'd7, pc, x, a, b, c);
            end
        end

        // R7: maskable request ignored while mask bit set
        tick();
        irq_n = 1'b0; ccr_i = 8'h10; instr_done = 1'b1; w0 = wn;
        tick(); instr_done = 1'b0;
        chk("R7 masked irq no busy", busy, 0);
        tick();
        chk("R7 masked irq still idle", busy, 0);
        chk("R7 masked irq no writes", wn - w0, 0);
        irq_n = 1'b1;

        // R8: non-maskable wins over unmasked maskable
        nmi_n = 1'b0; irq_n = 1'b0;
        tick();
        run_entry(2'd2, 16'h0180, 16'h4242, 16'h1111, 8'h22, 8'h33, 8'h05, 1'b0);
        irq_n = 1'b1;

        // R6: level held low does not retrigger
        tick();
        ccr_i = 8'h00; instr_done = 1'b1; w0 = wn;
        tick(); instr_done = 1'b0;
        chk("R6 held nmi no second entry", busy, 0);
        tick();
        chk("R6 held nmi no writes", wn - w0, 0);
        nmi_n = 1'b1;

        // R6: edge remembered across idle cycles
        nmi_edge();
        repeat (5) tick();
        chk("R6 no entry without boundary", busy, 0);
        run_entry(2'd2, 16'h0160, 16'hBEEF, 16'hCAFE, 8'h01, 8'hFE, 8'h2A, 1'b0);

        // R9: software trap first, pending non-maskable at next boundary
        nmi_edge();
        run_entry(2'd1, 16'h01A0, 16'h3000, 16'h0F0F, 8'h5A, 8'hA5, 8'h01, 1'b1);
        run_entry(2'd2, 16'h0199, 16'h2235, 16'h7777, 8'h66, 8'h99, 8'h00, 1'b0);

        // R9: no entry without a boundary even with requests present
        irq_n = 1'b0; ccr_i = 8'h00; swi_req = 1'b1;
        repeat (3) tick();
        chk("R9 no boundary no entry", busy, 0);
        swi_req = 1'b0; irq_n = 1'b1;

        // R2: reset during stacking
        tick();
        sp_i = 16'h01E0; swi_req = 1'b1; instr_done = 1'b1; w0 = wn;
        tick(); instr_done = 1'b0; swi_req = 1'b0;
        tick();
        tick();
        rst = 1'b1;
        chk("R2 writes before abort", wn - w0, 3);
        tick();
        tick();
        chk("R2 no writes after abort", wn - w0, 3);
        reset_seq("R2");
        chk("R2 no writes after reset", wn - w0, 3);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        wait (ticks > 150000);
        nvec++;
        nbad++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", ticks);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule